// File: doc/BRIEF.md
# Resonant Current Polarity Sampler with Dead-Time Blanking

This block sits beside the gate sequencer of a half-bridge resonant converter. It takes the one-bit output of a current-direction comparator, which is high while the resonant current is positive and low while it is negative. It also takes the high-side and low-side gate-on commands. The raw polarity is brought into the clock domain, and edge noise from the switching node is masked after every gate turn-off. The block keeps a qualified polarity and latches that polarity each time a gate command turns off. A protection stage elsewhere can then judge whether the converter is about to leave the zero-voltage-switching region.

A dead time begins at the clock edge on which a gate command is first seen low after being high. From that edge on, the qualified polarity is frozen for a programmable number of clock cycles. The counter that times this window restarts whenever another dead time begins. At each gate turn-off, the block compares the held polarity with the direction the current ought to have. After a high-side turn-off the current should be positive. After a low-side turn-off it should be negative. A wrong direction produces a single-cycle warning pulse.

Top module: `zps_polarity_sampler`

## Requirements
- R1: While reset is asserted (rstN low), qualPol, sampledPol and zcsWarn are all low.
- R2: With no blanking active, a change on polRaw appears on qualPol after the third rising clock edge that follows the change (two synchronizer flops, then the qualified register).
- R3: A dead time starts at a rising edge where hsOn or lsOn is sampled low and was sampled high at the previous edge. On the BLANK_CYCLES rising edges after that edge, qualPol keeps its value whatever polRaw does.
- R4: On rising edge BLANK_CYCLES+1 after the dead-time start, qualPol again loads the synchronized polarity.
- R5: If a new dead time starts while a blanking window is running, the window restarts and lasts a full BLANK_CYCLES edges from the new start.
- R6: At a dead-time start edge, sampledPol loads the qualPol value held just before that edge. It reads 1 for positive current and 0 for negative current.
- R7: After a high-side turn-off edge with qualPol low, or a low-side turn-off edge with qualPol high, zcsWarn is high for exactly the one cycle after that edge. A turn-off that sees the expected direction leaves zcsWarn low.
- R8: When both gate commands turn off on the same edge, zcsWarn pulses for one cycle, because one of the two direction checks always fails. sampledPol still loads qualPol.
- R9: On edges with no gate turn-off, sampledPol keeps its value and zcsWarn is low, whatever polRaw does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| polRaw | input | 1 | Asynchronous current-direction comparator output, 1 = positive |
| hsOn | input | 1 | High-side gate-on command, synchronous to clk |
| lsOn | input | 1 | Low-side gate-on command, synchronous to clk |
| qualPol | output | 1 | Synchronized polarity with dead-time blanking applied |
| sampledPol | output | 1 | Polarity latched at the most recent gate turn-off |
| zcsWarn | output | 1 | One-cycle pulse when the latched direction is wrong for the gate that turned off |

## Verification
Two events can land in the same cycle. The first is a gate turn-off that arrives while an earlier blanking window is still counting. The bench provokes this by issuing a short high-side pulse about a dozen cycles into a dead time. It then checks that qualPol stays frozen past the point where the first window would have ended and releases only a full window after the second start. The second is a simultaneous turn-off of both gates. The bench drives this directly and also lets the random phase produce it, then expects a single warning pulse together with a sample of the held polarity. A cycle-level reference model written from the requirements judges every cycle of the random phase.

// File: rtl/zps_pkg.sv
package zps_pkg;

  // Strobes handed from the gate-edge control to the polarity datapath.
  typedef struct packed {
    logic hiFall;   // high-side command turned off on this edge
    logic loFall;   // low-side command turned off on this edge
    logic blankOn;  // blanking window active, freeze the qualified polarity
  } zps_strobe_t;

endpackage

// File: rtl/zps_ctrl.sv
module zps_ctrl
  import zps_pkg::*;
#(
  parameter int BLANK_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsOn,
  input  logic        lsOn,
  output zps_strobe_t strobe
);

  localparam int CNT_W = (BLANK_CYCLES < 1) ? 1 : $clog2(BLANK_CYCLES + 1);

  logic hsPrev;
  logic lsPrev;
  logic hiFall;
  logic loFall;
  logic deadStart;

  // Gate command history for turn-off detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev <= 1'b0;
      lsPrev <= 1'b0;
    end else begin
      hsPrev <= hsOn;
      lsPrev <= lsOn;
    end
  end

  assign hiFall    = hsPrev & ~hsOn;
  assign loFall    = lsPrev & ~lsOn;
  assign deadStart = hiFall | loFall;

  logic blankOn;

  generate
    if (BLANK_CYCLES > 0) begin : g_blank
      logic [CNT_W-1:0] blankCnt;

      // Window counter: reloads at every dead-time start, then counts down.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          blankCnt <= '0;
        end else if (deadStart) begin
          blankCnt <= CNT_W'(BLANK_CYCLES);
        end else if (blankCnt != '0) begin
          blankCnt <= blankCnt - 1'b1;
        end
      end

      assign blankOn = (blankCnt != '0);
    end else begin : g_noblank
      assign blankOn = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.hiFall  = hiFall;
    strobe.loFall  = loFall;
    strobe.blankOn = blankOn;
  end

endmodule

// File: rtl/zps_datapath.sv
module zps_datapath
  import zps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        polRaw,
  input  zps_strobe_t strobe,
  output logic        qualPol,
  output logic        sampledPol,
  output logic        zcsWarn
);

  localparam int STAGES = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [STAGES-1:0] syncQ;
  logic              polSync;

  // Synchronizer chain for the asynchronous comparator output.
  generate
    for (genvar st = 0; st < STAGES; st++) begin : g_sync
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= polRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[st] <= 1'b0;
          else       syncQ[st] <= syncQ[st-1];
        end
      end
    end
  endgenerate

  assign polSync = syncQ[STAGES-1];

  logic turnOff;
  logic wrongDir;

  assign turnOff  = strobe.hiFall | strobe.loFall;
  assign wrongDir = (strobe.hiFall & ~qualPol) | (strobe.loFall & qualPol);

  // Qualified polarity: follows the synchronized input outside blanking.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualPol <= 1'b0;
    end else if (!strobe.blankOn) begin
      qualPol <= polSync;
    end
  end

  // Sample at each turn-off and flag a wrong current direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledPol <= 1'b0;
      zcsWarn    <= 1'b0;
    end else begin
      zcsWarn <= turnOff & wrongDir;
      if (turnOff) begin
        sampledPol <= qualPol;
      end
    end
  end

endmodule

// File: rtl/zps_polarity_sampler.sv
module zps_polarity_sampler
  import zps_pkg::*;
#(
  parameter int BLANK_CYCLES = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic polRaw,
  input  logic hsOn,
  input  logic lsOn,
  output logic qualPol,
  output logic sampledPol,
  output logic zcsWarn
);

  zps_strobe_t strobe;

  zps_ctrl #(
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .hsOn  (hsOn),
    .lsOn  (lsOn),
    .strobe(strobe)
  );

  zps_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .polRaw    (polRaw),
    .strobe    (strobe),
    .qualPol   (qualPol),
    .sampledPol(sampledPol),
    .zcsWarn   (zcsWarn)
  );

endmodule

// File: rtl/zps_checker.sv
module zps_checker #(
  parameter int BLANK_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic hsOn,
  input logic lsOn,
  input logic qualPol,
  input logic sampledPol,
  input logic zcsWarn
);

  logic hsD1, hsD2, lsD1, lsD2;
  int   winCnt;
  logic ckFall;

  assign ckFall = (hsD1 && !hsOn) || (lsD1 && !lsOn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsD1   <= 1'b0;
      hsD2   <= 1'b0;
      lsD1   <= 1'b0;
      lsD2   <= 1'b0;
      winCnt <= 0;
    end else begin
      hsD1 <= hsOn;
      hsD2 <= hsD1;
      lsD1 <= lsOn;
      lsD2 <= lsD1;
      if (ckFall)          winCnt <= BLANK_CYCLES;
      else if (winCnt > 0) winCnt <= winCnt - 1;
    end
  end

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winCnt > 0) |=> $stable(qualPol));

  // R7
  warn_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    zcsWarn |-> ((hsD2 && !hsD1) || (lsD2 && !lsD1)));

  // R7
  hi_wrong_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsD1 && !hsOn && !qualPol) |=> zcsWarn);

  // R7
  lo_wrong_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsD1 && !lsOn && qualPol) |=> zcsWarn);

  // R9
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ckFall |=> $stable(sampledPol));

endmodule

bind zps_polarity_sampler zps_checker #(.BLANK_CYCLES(BLANK_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hsOn      (hsOn),
  .lsOn      (lsOn),
  .qualPol   (qualPol),
  .sampledPol(sampledPol),
  .zcsWarn   (zcsWarn)
);

// File: tb/tb_zps_polarity_sampler.sv
`timescale 1ns/1ps
module tb_zps_polarity_sampler;

  localparam int BLANK = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic polRaw = 1'b0;
  logic hsOn = 1'b0;
  logic lsOn = 1'b0;
  logic qualPol, sampledPol, zcsWarn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  zps_polarity_sampler #(.BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .polRaw(polRaw), .hsOn(hsOn), .lsOn(lsOn),
    .qualPol(qualPol), .sampledPol(sampledPol), .zcsWarn(zcsWarn)
  );

  // Reference model written from the requirements.
  logic mS1, mS2, mQual, mSamp, mWarn, mHsPrev, mLsPrev;
  int   mBlank;

  function automatic logic expWarn(input logic hf, input logic lf, input logic q);
    return (hf && !q) || (lf && q);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mQual = 0; mSamp = 0; mWarn = 0;
      mHsPrev = 0; mLsPrev = 0; mBlank = 0;
    end else begin
      logic hf, lf, nQual;
      hf    = mHsPrev && !hsOn;
      lf    = mLsPrev && !lsOn;
      nQual = (mBlank != 0) ? mQual : mS2;
      mWarn = (hf || lf) ? expWarn(hf, lf, mQual) : 1'b0;
      if (hf || lf) mSamp = mQual;
      if (hf || lf)        mBlank = BLANK;
      else if (mBlank > 0) mBlank = mBlank - 1;
      mS2 = mS1; mS1 = polRaw; mQual = nQual;
      mHsPrev = hsOn; mLsPrev = lsOn;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkVal(input logic act, input logic exp, input string tag);
    chk(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic modelCmp();
    chkVal(qualPol,    mQual, "R3/R4 qualPol vs model");
    chkVal(sampledPol, mSamp, "R6 sampledPol vs model");
    chkVal(zcsWarn,    mWarn, "R7 zcsWarn vs model");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      modelCmp();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chkVal(qualPol, 1'b0, "R1 qualPol in reset");
    chkVal(sampledPol, 1'b0, "R1 sampledPol in reset");
    chkVal(zcsWarn, 1'b0, "R1 zcsWarn in reset");
    rstN = 1'b1;
    step(3);

    // R2 latency of three edges
    polRaw = 1'b1;
    step(2);
    chkVal(qualPol, 1'b0, "R2 qualPol before third edge");
    step(1);
    chkVal(qualPol, 1'b1, "R2 qualPol after third edge");

    // R6 high-side sample, R3/R4 window
    hsOn = 1'b1; step(2);
    hsOn = 1'b0; step(1);
    chkVal(sampledPol, 1'b1, "R6 sample at high-side turn-off");
    chkVal(zcsWarn, 1'b0, "R7 no warn on positive high-side");
    polRaw = 1'b0;
    step(20);
    chkVal(qualPol, 1'b1, "R3 held through window");
    step(1);
    chkVal(qualPol, 1'b0, "R4 released after window");

    // R7 low-side wrong direction pulse
    polRaw = 1'b1; step(25);
    lsOn = 1'b1; step(2);
    lsOn = 1'b0; step(1);
    chkVal(zcsWarn, 1'b1, "R7 warn on positive low-side");
    chkVal(sampledPol, 1'b1, "R6 sample at low-side turn-off");
    step(1);
    chkVal(zcsWarn, 1'b0, "R7 warn lasts one cycle");

    // R5 window restart
    hsOn = 1'b1; step(1);
    hsOn = 1'b0; step(1);
    polRaw = 1'b0; step(10);
    hsOn = 1'b1; step(1);
    hsOn = 1'b0; step(1);
    step(15);
    chkVal(qualPol, 1'b1, "R5 window restarted");
    step(10);
    chkVal(qualPol, 1'b0, "R5 released after restarted window");

    // R8 simultaneous turn-off
    hsOn = 1'b1; lsOn = 1'b1; step(2);
    hsOn = 1'b0; lsOn = 1'b0; step(1);
    chkVal(zcsWarn, 1'b1, "R8 warn on dual turn-off");
    chkVal(sampledPol, 1'b0, "R8 sample on dual turn-off");

    // R9 polarity activity without turn-off
    for (int i = 0; i < 30; i++) begin
      polRaw = ~polRaw;
      step(1);
      chkVal(sampledPol, 1'b0, "R9 sampledPol unchanged");
      chkVal(zcsWarn, 1'b0, "R9 no warn without turn-off");
    end

    // Random phase: alternating conduction with random dead gaps and noise.
    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int k = 0; k < 400; k++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 6)       begin hsOn = 1'b1; lsOn = 1'b0; end
        else if (r < 12) begin hsOn = 1'b0; lsOn = 1'b1; end
        else if (r < 20) begin hsOn = 1'b0; lsOn = 1'b0; end
        else if (r < 22) begin hsOn = 1'b1; lsOn = 1'b1; end
        if ($urandom_range(0, 9) < 3) polRaw = ~polRaw;
        step(1);
      end
    end
    hsOn = 1'b0; lsOn = 1'b0;
    step(30);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule